// File: doc/BRIEF.md
# Three-Axis Parity Repair Engine

This block keeps the correcting redundancy for a stacked memory built from dies, banks and rows. Every line address has three parity groups. The stack-row group holds all lines with the same row index across every die and bank. The die group holds all lines of one die. The bank group holds all lines of one bank index, taken across the dies. Each group has one parity line, kept in dedicated parity storage. Error detection is done elsewhere by a 32-bit line checksum. This block handles correction only.

Writes go through the block. Each write reads the old line, forms the old-XOR-new difference and folds it into all three parity lines that cover the address. When the checksum logic reports a bad line, the block picks a group that holds no other known-bad member, using the supplied fault list. It then rebuilds the line. It starts from that group's parity line and XORs in one group position per clock, skipping the bad line itself. At the end it raises a one-cycle done. If all three groups hold a second known fault, it reports failure.

In this model the memory array is a small internal register array.

Top module: `tdp_engine`

## Requirements
- R1: After reset, busy, done and fail are low, and every data line and parity line is zero. A rebuild of any line issued before any write returns zero.
- R2: An accepted write stores the new word and XORs (old ^ new) into the stack-row, die and bank parity lines of its address. A later rebuild of a line therefore returns the last value accepted for it, including after overwrites.
- R3: A line address is packed {die, bank, row}, with die in the top bits and row in the bottom bits. The defaults are 3 + 3 + 2 bits.
- R4: A rebuild report is accepted only when the block is idle. Busy reads high from the cycle after acceptance up to and including the done cycle. A report that arrives while busy is ignored and produces no extra done.
- R5: A write is ignored while busy, or in the same cycle as an accepted report.
- R6: The group is chosen in priority order. The stack-row group comes first; it is skipped if a valid fault entry other than the target has the same row. The die group comes next; it is skipped for a valid fault entry with the same die. The bank group comes last; it is skipped for a valid fault entry with the same bank. Invalid entries, and entries equal to the target, never block a group. rep_dim reports 1, 2 or 3 for the group used.
- R7: Done rises N clock edges after the accepting edge. N is DIES*BANKS for the stack-row group, BANKS*ROWS for the die group and DIES*ROWS for the bank group.
- R8: When all three groups are blocked, done and fail rise on the accepting edge itself, with rep_dim = 0.
- R9: Done is a single-cycle pulse, and rep_data holds the rebuilt line while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Write line address {die, bank, row} |
| wr_data | input | 16 | Write data |
| crc_fail | input | 1 | Bad-line report from the checksum logic |
| crc_addr | input | 8 | Address of the reported line |
| flt_vld | input | 4 | Valid bit for each fault-list entry |
| flt_addr | input | 32 | Fault-list addresses, entry i at bits [8i+7:8i] |
| rep_busy | output | 1 | Rebuild in progress |
| rep_done | output | 1 | Rebuild finished (one cycle) |
| rep_fail | output | 1 | No usable group, qualified by done |
| rep_dim | output | 2 | Group used: 1 stack-row, 2 die, 3 bank, 0 none |
| rep_data | output | 16 | Rebuilt line |

## Verification
The rebuild is tried with a fault list that is empty, and with lists whose entries share only the row, the row and the die, or all three coordinates with the target. These cases show whether each group is blocked by the right coordinate and whether the priority order holds. Further patterns use an entry that equals the target, an invalid entry, and an entry that shares die and bank but not row. They separate correct skip logic from over-eager blocking. Rebuilt values follow overwrites of lines in the same row, die and bank, so a wrong parity delta shows up in the rebuilt data. The completion latency of each group tells whether the right members are walked.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  typedef enum logic [1:0] {
    DIM_NONE  = 2'd0,
    DIM_STACK = 2'd1,
    DIM_DIE   = 2'd2,
    DIM_BANK  = 2'd3
  } dim_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } st_e;
endpackage

// File: rtl/tdp_parity_store.sv
module tdp_parity_store
  import tdp_pkg::*;
#(
  parameter int DIES  = 8,
  parameter int BANKS = 8,
  parameter int ROWS  = 4,
  parameter int W     = 16,
  localparam int DW = $clog2(DIES),
  localparam int BW = $clog2(BANKS),
  localparam int RW = $clog2(ROWS),
  localparam int AW = DW + BW + RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  dim_e          par_sel,
  input  logic [AW-1:0] par_addr,
  output logic [W-1:0]  par_data
);
  localparam int LINES = 1 << AW;

  logic [W-1:0] mem   [LINES];
  logic [W-1:0] p_row [ROWS];
  logic [W-1:0] p_die [DIES];
  logic [W-1:0] p_bnk [BANKS];

  logic [DW-1:0] w_die, q_die;
  logic [BW-1:0] w_bnk, q_bnk;
  logic [RW-1:0] w_row, q_row;
  logic [W-1:0]  delta;

  always_comb begin
    {w_die, w_bnk, w_row} = wr_addr;
    {q_die, q_bnk, q_row} = par_addr;
    delta   = mem[wr_addr] ^ wr_data;
    rd_data = mem[rd_addr];
    case (par_sel)
      DIM_STACK: par_data = p_row[q_row];
      DIM_DIE:   par_data = p_die[q_die];
      DIM_BANK:  par_data = p_bnk[q_bnk];
      default:   par_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) mem[i] <= '0;
      for (int i = 0; i < ROWS; i++)  p_row[i] <= '0;
      for (int i = 0; i < DIES; i++)  p_die[i] <= '0;
      for (int i = 0; i < BANKS; i++) p_bnk[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
      p_row[w_row] <= p_row[w_row] ^ delta;
      p_die[w_die] <= p_die[w_die] ^ delta;
      p_bnk[w_bnk] <= p_bnk[w_bnk] ^ delta;
    end
  end

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/tdp_group_select.sv
module tdp_group_select
  import tdp_pkg::*;
#(
  parameter int DW = 3,
  parameter int BW = 3,
  parameter int RW = 2,
  parameter int NF = 4,
  localparam int AW = DW + BW + RW
) (
  input  logic [AW-1:0]    tgt_addr,
  input  logic [NF-1:0]    flt_vld,
  input  logic [NF*AW-1:0] flt_addr,
  output dim_e             sel_dim
);
  logic blk_row, blk_die, blk_bnk;

  always_comb begin
    blk_row = 1'b0;
    blk_die = 1'b0;
    blk_bnk = 1'b0;
    for (int i = 0; i < NF; i++) begin
      if (flt_vld[i] && (flt_addr[i*AW +: AW] != tgt_addr)) begin
        if (flt_addr[i*AW +: RW] == tgt_addr[RW-1:0])
          blk_row = 1'b1;
        if (flt_addr[i*AW+RW+BW +: DW] == tgt_addr[AW-1 -: DW])
          blk_die = 1'b1;
        if (flt_addr[i*AW+RW +: BW] == tgt_addr[RW +: BW])
          blk_bnk = 1'b1;
      end
    end
    if (!blk_row)      sel_dim = DIM_STACK;
    else if (!blk_die) sel_dim = DIM_DIE;
    else if (!blk_bnk) sel_dim = DIM_BANK;
    else               sel_dim = DIM_NONE;
  end
endmodule

// File: rtl/tdp_rebuild_seq.sv
module tdp_rebuild_seq
  import tdp_pkg::*;
#(
  parameter int DW = 3,
  parameter int BW = 3,
  parameter int RW = 2,
  parameter int W  = 16,
  localparam int AW = DW + BW + RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  dim_e          sel_dim,
  input  logic [W-1:0]  par_data,
  output logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  rd_data,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [1:0]    dim,
  output logic [W-1:0]  data
);
  localparam int C1 = DW + BW;
  localparam int C2 = BW + RW;
  localparam int C3 = DW + RW;
  localparam int CM = (C1 > C2) ? C1 : C2;
  localparam int CW = (CM > C3) ? CM : C3;
  localparam logic [CW-1:0] LAST1 = CW'((1 << C1) - 1);
  localparam logic [CW-1:0] LAST2 = CW'((1 << C2) - 1);
  localparam logic [CW-1:0] LAST3 = CW'((1 << C3) - 1);

  st_e           st_q, st_n;
  dim_e          dim_q, dim_n;
  logic [CW-1:0] cnt_q, cnt_n, last;
  logic [AW-1:0] tgt_q, tgt_n;
  logic [W-1:0]  acc_q, acc_n;

  always_comb begin
    case (dim_q)
      DIM_STACK: rd_addr = {cnt_q[C1-1:0], tgt_q[RW-1:0]};
      DIM_DIE:   rd_addr = {tgt_q[AW-1 -: DW], cnt_q[C2-1:0]};
      default:   rd_addr = {cnt_q[C3-1:RW], tgt_q[RW +: BW], cnt_q[RW-1:0]};
    endcase
    case (dim_q)
      DIM_STACK: last = LAST1;
      DIM_DIE:   last = LAST2;
      default:   last = LAST3;
    endcase
  end

  always_comb begin
    st_n  = st_q;
    dim_n = dim_q;
    cnt_n = cnt_q;
    tgt_n = tgt_q;
    acc_n = acc_q;
    case (st_q)
      ST_IDLE: if (start) begin
        tgt_n = start_addr;
        dim_n = sel_dim;
        cnt_n = '0;
        if (sel_dim == DIM_NONE) begin
          acc_n = '0;
          st_n  = ST_DONE;
        end else begin
          acc_n = par_data;
          st_n  = ST_RUN;
        end
      end
      ST_RUN: begin
        if (rd_addr != tgt_q) acc_n = acc_q ^ rd_data;
        cnt_n = cnt_q + CW'(1);
        if (cnt_q == last) st_n = ST_DONE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dim_q <= DIM_NONE;
      cnt_q <= '0;
      tgt_q <= '0;
      acc_q <= '0;
    end else begin
      st_q  <= st_n;
      dim_q <= dim_n;
      cnt_q <= cnt_n;
      tgt_q <= tgt_n;
      acc_q <= acc_n;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = (st_q == ST_DONE);
  assign fail = done && (dim_q == DIM_NONE);
  assign dim  = dim_q;
  assign data = acc_q;

  // R4
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R8
  fail_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && sel_dim == DIM_NONE) |=> (done && fail));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  no_early_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: rtl/tdp_engine.sv
module tdp_engine
  import tdp_pkg::*;
#(
  parameter int DIES  = 8,
  parameter int BANKS = 8,
  parameter int ROWS  = 4,
  parameter int W     = 16,
  parameter int NF    = 4,
  localparam int DW = $clog2(DIES),
  localparam int BW = $clog2(BANKS),
  localparam int RW = $clog2(ROWS),
  localparam int AW = DW + BW + RW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic             crc_fail,
  input  logic [AW-1:0]    crc_addr,
  input  logic [NF-1:0]    flt_vld,
  input  logic [NF*AW-1:0] flt_addr,
  output logic             rep_busy,
  output logic             rep_done,
  output logic             rep_fail,
  output logic [1:0]       rep_dim,
  output logic [W-1:0]     rep_data
);
  dim_e          sel_dim;
  logic          wr_ok;
  logic [AW-1:0] rd_addr;
  logic [W-1:0]  rd_data, par_data;

  assign wr_ok = wr_en && !rep_busy && !crc_fail;

  tdp_parity_store #(.DIES(DIES), .BANKS(BANKS), .ROWS(ROWS), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_ok), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .par_sel(sel_dim), .par_addr(crc_addr), .par_data(par_data)
  );

  tdp_group_select #(.DW(DW), .BW(BW), .RW(RW), .NF(NF)) u_sel (
    .tgt_addr(crc_addr), .flt_vld(flt_vld), .flt_addr(flt_addr),
    .sel_dim(sel_dim)
  );

  tdp_rebuild_seq #(.DW(DW), .BW(BW), .RW(RW), .W(W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(crc_fail), .start_addr(crc_addr), .sel_dim(sel_dim),
    .par_data(par_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(rep_busy), .done(rep_done), .fail(rep_fail),
    .dim(rep_dim), .data(rep_data)
  );
endmodule

// File: tb/tdp_engine_tb_top.sv
`timescale 1ns/1ps
module tdp_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic        crc_fail;
  logic [7:0]  crc_addr;
  logic [3:0]  flt_vld;
  logic [31:0] flt_addr;
  logic        rep_busy, rep_done, rep_fail;
  logic [1:0]  rep_dim;
  logic [15:0] rep_data;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [256];

  always #2 clk = ~clk;

  tdp_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .crc_fail(crc_fail), .crc_addr(crc_addr),
    .flt_vld(flt_vld), .flt_addr(flt_addr), .rep_busy(rep_busy),
    .rep_done(rep_done), .rep_fail(rep_fail), .rep_dim(rep_dim),
    .rep_data(rep_data)
  );

  // {addr, data}
  localparam logic [23:0] WR_VEC [16] = '{
    {8'h2B, 16'h1234}, {8'h00, 16'hBEEF}, {8'hFF, 16'h0F0F}, {8'hE9, 16'h5A5A},
    {8'h38, 16'h1111}, {8'hA3, 16'h2222}, {8'h2B, 16'h9876}, {8'h28, 16'h3333},
    {8'h03, 16'h4444}, {8'h01, 16'h7777}, {8'hE0, 16'h8888}, {8'h00, 16'hC0DE},
    {8'h2A, 16'h0101}, {8'h6B, 16'h0202}, {8'hE9, 16'hA5A5}, {8'h13, 16'hFEED}
  };

  // {target, valid[2:0], a2, a1, a0, expected group}
  localparam logic [36:0] REP_VEC [9] = '{
    {8'h00, 3'b000, 8'h00, 8'h00, 8'h00, 2'd1},
    {8'h2B, 3'b001, 8'h00, 8'h00, 8'hA3, 2'd2},
    {8'h2B, 3'b011, 8'h00, 8'h38, 8'hA3, 2'd3},
    {8'h2B, 3'b001, 8'h00, 8'h00, 8'h28, 2'd1},
    {8'h2B, 3'b111, 8'hE9, 8'h38, 8'hA3, 2'd0},
    {8'h2B, 3'b001, 8'h00, 8'h00, 8'h2B, 2'd1},
    {8'h2B, 3'b000, 8'h00, 8'h00, 8'hA3, 2'd1},
    {8'hE9, 3'b011, 8'h00, 8'hE0, 8'h01, 2'd3},
    {8'hFF, 3'b001, 8'h00, 8'h00, 8'h03, 2'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
  endtask

  function automatic int lat_of(input logic [1:0] g);
    case (g)
      2'd1: return 64;
      2'd2: return 32;
      2'd3: return 32;
      default: return 0;
    endcase
  endfunction

  // Accepts a report, waits for done, checks group, latency, status and data.
  task automatic do_rep(input logic [7:0] tgt, input logic [2:0] v,
                        input logic [23:0] fa, input logic [1:0] eg, input string tag);
    int lat;
    @(negedge clk);
    crc_fail = 1'b1; crc_addr = tgt;
    flt_vld = {1'b0, v}; flt_addr = {8'h00, fa};
    @(posedge clk); #1;
    crc_fail = 1'b0;
    chk({tag, " R4 busy after accept"}, rep_busy, 1'b1);
    lat = 0;
    while (!rep_done && lat < 200) begin
      @(posedge clk); #1; lat++;
    end
    chk({tag, " R7 latency"}, lat, lat_of(eg));
    chk({tag, " R6 group"}, rep_dim, eg);
    chk({tag, " R8 fail flag"}, rep_fail, (eg == 2'd0));
    chk({tag, " R2 rebuilt data"}, rep_data, (eg == 2'd0) ? 16'h0 : model[tgt]);
    @(posedge clk); #1;
    chk({tag, " R9 done pulse"}, rep_done, 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    crc_fail = 1'b0; crc_addr = '0; flt_vld = '0; flt_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy at reset", rep_busy, 1'b0);
    chk("R1 done at reset", rep_done, 1'b0);
    chk("R1 fail at reset", rep_fail, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R1: rebuild before any write returns zero
    do_rep(8'h2B, 3'b000, 24'h0, 2'd1, "R1 fresh");

    for (int i = 0; i < 16; i++) do_write(WR_VEC[i][23:16], WR_VEC[i][15:0]);

    // R3 R6 table-driven group selection
    for (int i = 0; i < 9; i++)
      do_rep(REP_VEC[i][36:29], REP_VEC[i][28:26], REP_VEC[i][25:2],
             REP_VEC[i][1:0], $sformatf("R3 case%0d", i));

    // R4 R5: report and write during a rebuild are ignored
    begin
      int lat;
      int extra;
      @(negedge clk);
      crc_fail = 1'b1; crc_addr = 8'h00; flt_vld = '0;
      @(posedge clk); #1;
      crc_fail = 1'b0;
      lat = 0;
      while (!rep_done && lat < 200) begin
        if (lat == 5) begin
          @(negedge clk);
          crc_fail = 1'b1; crc_addr = 8'hE9;
          wr_en = 1'b1; wr_addr = 8'h00; wr_data = 16'hDEAD;
          @(negedge clk);
          crc_fail = 1'b0; wr_en = 1'b0;
          @(posedge clk); #1; lat += 2;
        end else begin
          @(posedge clk); #1; lat++;
        end
      end
      chk("R4 latency with stray report", lat, 64);
      chk("R5 data unaffected by busy write", rep_data, model[8'h00]);
      extra = 0;
      for (int k = 0; k < 80; k++) begin
        @(posedge clk); #1;
        if (rep_done) extra++;
      end
      chk("R4 no extra done", extra, 0);
      chk("R4 idle after rebuild", rep_busy, 1'b0);
    end
    do_rep(8'h00, 3'b000, 24'h0, 2'd1, "R5 after busy write");

    // R5: write in the same cycle as an accepted report is dropped
    @(negedge clk);
    crc_fail = 1'b1; crc_addr = 8'hFF; flt_vld = '0;
    wr_en = 1'b1; wr_addr = 8'hFF; wr_data = 16'h6666;
    @(negedge clk);
    crc_fail = 1'b0; wr_en = 1'b0;
    while (rep_busy) @(negedge clk);
    do_rep(8'hFF, 3'b000, 24'h0, 2'd1, "R5 same-cycle write");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule